// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block fetches transmit work from a ring of 32-byte descriptors held in host memory and turns it into a byte stream. A single-cycle poll kick starts it. From then on it works through the ring one descriptor at a time, starting at its current-pointer register. For each descriptor that hardware owns, it reads the buffer bytes through a word-wide memory master and sends them out on a valid/ready byte stream. When the descriptor closes a frame, the final byte carries an end-of-frame marker. The block then returns the descriptor to software by clearing the ownership flag in its control word, and moves the pointer on.

A descriptor holds eight little-endian words. Offset 0 is the control word. Offset 4 holds two 16-bit size fields: buffer 1 in the low half and buffer 2 in the high half. Offset 8 is the buffer start address. The walker never reads the remaining words.

Three control bits matter: bit 31 is ownership, bit 29 marks the last segment, and bit 21 makes the ring wrap back to the base address. When a frame completes, the walker emits one-cycle set pulses for a transmit-done flag and a normal-summary flag, which a separate register file collects. A further pulse reports a badly programmed size. The transfer still goes ahead after that pulse.

Top module: `txdesc_ring_walker`

## Requirements
- R1: After reset the memory request, stream valid and all three set pulses are low and the current pointer is 0.
- R2: A base-load pulse copies the base address input into the current pointer.
- R3: A kick makes the walker read the control word at the current pointer. If bit 31 of that word is 0, the walker returns to idle. It sends no bytes, writes nothing and leaves the pointer unchanged.
- R4: The byte count of a descriptor is size[11:0] + size[27:16]. That many bytes are read starting at the buffer address at offset 8, at any byte alignment. The byte at address A is taken from bits 8*(A mod 4)+7 down to 8*(A mod 4) of the word at A with its low two bits cleared.
- R5: The stream last flag is high only on the final byte of a descriptor whose control bit 29 is 1. A descriptor with a byte count of zero sends no bytes.
- R6: After a descriptor's bytes have been sent, its control word is written back to the address it was read from. Bit 31 is cleared and every other bit is unchanged.
- R7: After the write-back, the current pointer reloads from the base address input if control bit 21 was 1. Otherwise it advances by 32.
- R8: A write-back of a descriptor with bit 29 set produces exactly one single-cycle pulse on both the transmit-done and summary outputs. Other descriptors produce none.
- R9: A single-cycle size-error pulse is raised when size[11:0] is above 2048 or size[27:16] is non-zero. The walker still sends the full byte count.
- R10: While the stream is stalled (valid high, ready low), data and last hold steady. No memory request is raised while stream valid is high.
- R11: A kick that arrives while the walker is busy is remembered. After the walker returns to idle, it makes one more ownership check at the current pointer.
- R12: After one descriptor, the walker goes straight on to the next, and stops only at an unowned one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kick_i | input | 1 | Poll demand pulse |
| base_load_i | input | 1 | Copy base address into current pointer |
| tx_base_i | input | AW | Ring base address |
| cur_ptr_o | output | AW | Current descriptor pointer |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | 1 for write, 0 for read |
| mem_addr_o | output | AW | Byte address, word aligned |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Request completed this cycle |
| mem_rdata_i | input | 32 | Read data, valid with acknowledge |
| tx_tdata_o | output | 8 | Stream byte |
| tx_tvalid_o | output | 1 | Stream byte valid |
| tx_tready_i | input | 1 | Stream sink ready |
| tx_tlast_o | output | 1 | Final byte of frame |
| ti_set_o | output | 1 | Transmit-done set pulse |
| nis_set_o | output | 1 | Normal summary set pulse |
| len_err_o | output | 1 | Size programming error pulse |

## Verification
Two events in this block can land in the same cycle. One is a new kick. The other is the completion of an ownership check that finds the descriptor unowned and sends the walker back to idle. If the kick lands in that cycle it must still be remembered, not lost. The bench memory model provokes the clash by driving the kick in the very cycle in which it acknowledges the read of the watched unowned control word. The outcome is judged by counting reads of that address: two reads show the kick was latched and re-checked, one read shows it was dropped.

// File: rtl/txw_pkg.sv
package txw_pkg;

  localparam int OWN_BIT  = 31;
  localparam int LAST_BIT = 29;
  localparam int WRAP_BIT = 21;
  localparam int CNT_W    = 13;

  typedef enum logic [2:0] {
    S_IDLE, S_CTL, S_SIZE, S_BUF, S_DRD, S_DTX, S_WB
  } walk_st_t;

  function automatic logic [CNT_W-1:0] seg_len(input logic [11:0] a,
                                               input logic [11:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  function automatic logic size_bad(input logic [11:0] a,
                                    input logic [11:0] b,
                                    input int unsigned lim);
    return (32'(a) > lim) || (b != 12'd0);
  endfunction

  function automatic logic [2:0] chunk(input logic [1:0] off,
                                       input logic [CNT_W-1:0] rem);
    logic [2:0] room;
    room = 3'd4 - {1'b0, off};
    return (rem < CNT_W'(room)) ? rem[2:0] : room;
  endfunction

endpackage

// File: rtl/txw_ring_ptr.sv
module txw_ring_ptr #(
  parameter int AW   = 32,
  parameter int STEP = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic          step_i,
  input  logic          wrap_i,
  output logic [AW-1:0] ptr_o
);

  logic [AW-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       ptr_q <= '0;
    else if (load_i)  ptr_q <= base_i;
    else if (step_i)  ptr_q <= wrap_i ? base_i : ptr_q + AW'(STEP);
  end

  assign ptr_o = ptr_q;

  p_ptr_advance_r7: assert property (@(posedge clk) disable iff (!rst_n)
    step_i && !wrap_i && !load_i |=> ptr_o == $past(ptr_o) + AW'(STEP));

  p_ptr_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    step_i && wrap_i && !load_i |=> ptr_o == $past(base_i));

  p_base_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> ptr_o == $past(base_i));

endmodule

// File: rtl/txw_byte_lane.sv
module txw_byte_lane (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load_i,
  input  logic [31:0] word_i,
  input  logic [1:0]  off_i,
  input  logic [2:0]  cnt_i,
  input  logic        last_i,
  input  logic        ready_i,
  output logic        valid_o,
  output logic [7:0]  data_o,
  output logic        last_o,
  output logic        busy_o
);

  logic [31:0] word_q;
  logic [1:0]  idx_q;
  logic [2:0]  left_q;
  logic        last_q;
  logic        take_w;

  assign valid_o = (left_q != 3'd0);
  assign busy_o  = valid_o;
  assign data_o  = word_q[{idx_q, 3'b000} +: 8];
  assign last_o  = last_q && (left_q == 3'd1);
  assign take_w  = valid_o && ready_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
      idx_q  <= '0;
      left_q <= '0;
      last_q <= 1'b0;
    end else if (load_i) begin
      word_q <= word_i;
      idx_q  <= off_i;
      left_q <= cnt_i;
      last_q <= last_i;
    end else if (take_w) begin
      idx_q  <= idx_q + 2'd1;
      left_q <= left_q - 3'd1;
    end
  end

  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !ready_i |=> valid_o && $stable(data_o) && $stable(last_o));

  p_load_when_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !valid_o);

  p_last_needs_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o);

endmodule

// File: rtl/txw_walk_seq.sv
module txw_walk_seq
  import txw_pkg::*;
#(
  parameter int AW     = 32,
  parameter int MAX_B1 = 2048
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          kick_i,
  input  logic [AW-1:0] cur_ptr_i,
  input  logic          mem_ack_i,
  input  logic [31:0]   mem_rdata_i,
  input  logic          lane_busy_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  output logic          lane_load_o,
  output logic [31:0]   lane_word_o,
  output logic [1:0]    lane_off_o,
  output logic [2:0]    lane_cnt_o,
  output logic          lane_last_o,
  output logic          step_o,
  output logic          wrap_o,
  output logic          ti_set_o,
  output logic          nis_set_o,
  output logic          len_err_o
);

  walk_st_t         state_q;
  logic [31:0]      ctl_q;
  logic [AW-1:0]    buf_q;
  logic [CNT_W-1:0] rem_q;
  logic             pend_q;
  logic             ti_q, nis_q, err_q;

  // named events
  logic       go_w, ctl_ack_w, size_ack_w, buf_ack_w, data_ack_w, wb_ack_w;
  logic [2:0] chunk_w;

  assign go_w       = kick_i || pend_q;
  assign ctl_ack_w  = (state_q == S_CTL)  && mem_ack_i;
  assign size_ack_w = (state_q == S_SIZE) && mem_ack_i;
  assign buf_ack_w  = (state_q == S_BUF)  && mem_ack_i;
  assign data_ack_w = (state_q == S_DRD)  && mem_ack_i;
  assign wb_ack_w   = (state_q == S_WB)   && mem_ack_i;
  assign chunk_w    = chunk(buf_q[1:0], rem_q);

  always_comb begin
    mem_req_o = 1'b0;
    unique case (state_q)
      S_CTL, S_SIZE, S_BUF, S_WB: mem_req_o = 1'b1;
      S_DRD:                      mem_req_o = !lane_busy_i;
      default:                    mem_req_o = 1'b0;
    endcase
  end

  always_comb begin
    unique case (state_q)
      S_SIZE:  mem_addr_o = cur_ptr_i + AW'(4);
      S_BUF:   mem_addr_o = cur_ptr_i + AW'(8);
      S_DRD:   mem_addr_o = {buf_q[AW-1:2], 2'b00};
      default: mem_addr_o = cur_ptr_i;
    endcase
  end

  assign mem_we_o    = (state_q == S_WB);
  assign mem_wdata_o = ctl_q & ~(32'd1 << OWN_BIT);

  assign lane_load_o = data_ack_w;
  assign lane_word_o = mem_rdata_i;
  assign lane_off_o  = buf_q[1:0];
  assign lane_cnt_o  = chunk_w;
  assign lane_last_o = ctl_q[LAST_BIT] && (rem_q == CNT_W'(chunk_w));

  assign step_o = wb_ack_w;
  assign wrap_o = ctl_q[WRAP_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      ctl_q   <= '0;
      buf_q   <= '0;
      rem_q   <= '0;
      pend_q  <= 1'b0;
      ti_q    <= 1'b0;
      nis_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (go_w) state_q <= S_CTL;
        S_CTL: if (mem_ack_i) begin
          ctl_q   <= mem_rdata_i;
          state_q <= mem_rdata_i[OWN_BIT] ? S_SIZE : S_IDLE;
        end
        S_SIZE: if (mem_ack_i) begin
          rem_q   <= seg_len(mem_rdata_i[11:0], mem_rdata_i[27:16]);
          state_q <= S_BUF;
        end
        S_BUF: if (mem_ack_i) begin
          buf_q   <= mem_rdata_i[AW-1:0];
          state_q <= (rem_q == '0) ? S_WB : S_DRD;
        end
        S_DRD: if (mem_ack_i) begin
          buf_q   <= buf_q + AW'(chunk_w);
          rem_q   <= rem_q - CNT_W'(chunk_w);
          state_q <= S_DTX;
        end
        S_DTX: if (!lane_busy_i) state_q <= (rem_q == '0) ? S_WB : S_DRD;
        S_WB:  if (mem_ack_i) state_q <= S_CTL;
        default: state_q <= S_IDLE;
      endcase

      if (state_q == S_IDLE) pend_q <= 1'b0;
      else if (kick_i)       pend_q <= 1'b1;

      err_q <= size_ack_w && size_bad(mem_rdata_i[11:0], mem_rdata_i[27:16],
                                      MAX_B1);
      ti_q  <= wb_ack_w && ctl_q[LAST_BIT];
      nis_q <= wb_ack_w && ctl_q[LAST_BIT];
    end
  end

  assign ti_set_o  = ti_q;
  assign nis_set_o = nis_q;
  assign len_err_o = err_q;

  p_unowned_stops_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_ack_w && !mem_rdata_i[OWN_BIT] |=> state_q == S_IDLE);

  p_owned_proceeds_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_ack_w && mem_rdata_i[OWN_BIT] |=> state_q == S_SIZE);

  p_pending_recheck_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE) && pend_q |=> state_q == S_CTL);

  p_wb_clears_own_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && mem_we_o |-> !mem_wdata_o[OWN_BIT]);

  p_ti_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ti_set_o |=> !ti_set_o);

  p_err_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    len_err_o |=> !len_err_o);

  p_buf_ack_path_r4: assert property (@(posedge clk) disable iff (!rst_n)
    buf_ack_w |=> (state_q == S_WB) || (state_q == S_DRD));

endmodule

// File: rtl/txdesc_ring_walker.sv
module txdesc_ring_walker
  import txw_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DESC_BYTES = 32,
  parameter int MAX_B1     = 2048
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          kick_i,
  input  logic          base_load_i,
  input  logic [AW-1:0] tx_base_i,
  output logic [AW-1:0] cur_ptr_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  input  logic          mem_ack_i,
  input  logic [31:0]   mem_rdata_i,
  output logic [7:0]    tx_tdata_o,
  output logic          tx_tvalid_o,
  input  logic          tx_tready_i,
  output logic          tx_tlast_o,
  output logic          ti_set_o,
  output logic          nis_set_o,
  output logic          len_err_o
);

  logic        lane_busy_w, lane_load_w, lane_last_w;
  logic [31:0] lane_word_w;
  logic [1:0]  lane_off_w;
  logic [2:0]  lane_cnt_w;
  logic        step_w, wrap_w;

  txw_ring_ptr #(.AW(AW), .STEP(DESC_BYTES)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (base_load_i),
    .base_i (tx_base_i),
    .step_i (step_w),
    .wrap_i (wrap_w),
    .ptr_o  (cur_ptr_o)
  );

  txw_walk_seq #(.AW(AW), .MAX_B1(MAX_B1)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .kick_i      (kick_i),
    .cur_ptr_i   (cur_ptr_o),
    .mem_ack_i   (mem_ack_i),
    .mem_rdata_i (mem_rdata_i),
    .lane_busy_i (lane_busy_w),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .lane_load_o (lane_load_w),
    .lane_word_o (lane_word_w),
    .lane_off_o  (lane_off_w),
    .lane_cnt_o  (lane_cnt_w),
    .lane_last_o (lane_last_w),
    .step_o      (step_w),
    .wrap_o      (wrap_w),
    .ti_set_o    (ti_set_o),
    .nis_set_o   (nis_set_o),
    .len_err_o   (len_err_o)
  );

  txw_byte_lane u_lane (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (lane_load_w),
    .word_i  (lane_word_w),
    .off_i   (lane_off_w),
    .cnt_i   (lane_cnt_w),
    .last_i  (lane_last_w),
    .ready_i (tx_tready_i),
    .valid_o (tx_tvalid_o),
    .data_o  (tx_tdata_o),
    .last_o  (tx_tlast_o),
    .busy_o  (lane_busy_w)
  );

  p_no_read_while_streaming_r10: assert property (@(posedge clk)
    disable iff (!rst_n) mem_req_o |-> !tx_tvalid_o);

  p_req_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o)
                                 && $stable(mem_we_o));

  p_pulse_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ti_set_o |-> nis_set_o);

  p_word_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> mem_addr_o[1:0] == 2'b00);

endmodule

// File: tb/txdesc_ring_walker_tb_top.sv
module txdesc_ring_walker_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        kick = 1'b0;
  logic        base_load = 1'b0;
  logic [31:0] tx_base = '0;
  logic [31:0] cur_ptr;
  logic        req, we, ack = 1'b0;
  logic [31:0] addr, wdata, rdata = '0;
  logic [7:0]  tdata;
  logic        tvalid, tready = 1'b0, tlast;
  logic        ti_set, nis_set, len_err;

  int checks = 0, errors = 0;
  int ti_cnt = 0, nis_cnt = 0, err_cnt = 0;
  int stall_viol = 0, hold_viol = 0;
  int ready_pct = 100;
  logic [31:0] watch_addr = 32'hffff_ffff, coincide_addr = 32'hffff_ffff;
  int watch_cnt = 0;
  logic [31:0] mem [0:4095];
  logic [8:0]  exp_q [$];

  txdesc_ring_walker dut_i (
    .clk(clk), .rst_n(rst_n), .kick_i(kick), .base_load_i(base_load),
    .tx_base_i(tx_base), .cur_ptr_o(cur_ptr),
    .mem_req_o(req), .mem_we_o(we), .mem_addr_o(addr), .mem_wdata_o(wdata),
    .mem_ack_i(ack), .mem_rdata_i(rdata),
    .tx_tdata_o(tdata), .tx_tvalid_o(tvalid), .tx_tready_i(tready),
    .tx_tlast_o(tlast),
    .ti_set_o(ti_set), .nis_set_o(nis_set), .len_err_o(len_err)
  );

  initial forever #4 clk = ~clk;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", rq, what, act, exp);
    end
  endtask

  task automatic put_byte(input logic [31:0] a, input logic [7:0] v);
    mem[a[13:2]][{a[1:0], 3'b000} +: 8] = v;
  endtask

  // driver: builds a descriptor and pushes the bytes it should produce
  task automatic make_desc(input logic [31:0] da, input logic [31:0] ctl,
                           input int b1, input int b2,
                           input logic [31:0] ba, input logic [7:0] seed);
    int n;
    logic [7:0] v;
    n = b1 + b2;
    mem[da[13:2]]     = ctl;
    mem[da[13:2] + 1] = {16'(b2), 16'(b1)};
    mem[da[13:2] + 2] = ba;
    for (int k = 3; k < 8; k++) mem[da[13:2] + 12'(k)] = '0;
    for (int i = 0; i < n; i++) begin
      v = seed + 8'(i * 7);
      put_byte(ba + 32'(i), v);
      if (ctl[31]) exp_q.push_back({ctl[29] && (i == n - 1), v});
    end
  endtask

  task automatic pulse_kick();
    @(negedge clk); kick = 1'b1;
    @(negedge clk); kick = 1'b0;
  endtask

  task automatic wait_idle();
    int quiet;
    quiet = 0;
    while (quiet < 20) begin
      @(negedge clk);
      if (req || tvalid) quiet = 0;
      else quiet++;
    end
  endtask

  // memory responder
  initial begin
    int stall;
    bit kick_mine;
    stall = 0;
    kick_mine = 0;
    forever begin
      @(negedge clk);
      if (kick_mine) begin kick = 1'b0; kick_mine = 0; end
      if (ack) ack = 1'b0;
      else if (req) begin
        if (stall > 0) stall--;
        else begin
          ack = 1'b1;
          if (we) mem[addr[13:2]] = wdata;
          else begin
            rdata = mem[addr[13:2]];
            if (addr == watch_addr) watch_cnt++;
            if (addr == coincide_addr) begin
              kick = 1'b1; kick_mine = 1; coincide_addr = 32'hffff_ffff;
            end
          end
          stall = $urandom_range(0, 2);
        end
      end
    end
  end

  // monitor: stream scoreboard and pulse counters
  initial begin
    logic [8:0] got, exp, prev_word;
    bit prev_stall;
    prev_stall = 0;
    prev_word = '0;
    forever begin
      @(negedge clk);
      tready = ($urandom_range(0, 99) < ready_pct);
      #1;
      if (rst_n) begin
        if (req && tvalid) stall_viol++;
        if (prev_stall && (!tvalid || {tlast, tdata} != prev_word)) hold_viol++;
        prev_stall = tvalid && !tready;
        prev_word = {tlast, tdata};
        if (ti_set) ti_cnt++;
        if (nis_set) nis_cnt++;
        if (len_err) err_cnt++;
        if (tvalid && tready) begin
          got = {tlast, tdata};
          if (exp_q.size() == 0) chk(0, "R4", "unexpected byte", 32'(got), 0);
          else begin
            exp = exp_q.pop_front();
            chk(got == exp, "R4", "data, R5 last flag", 32'(got), 32'(exp));
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "R12", "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int t0, n0, e0;
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(!req && !tvalid, "R1", "req/valid after reset", {30'd0, req, tvalid}, 0);
    chk(!ti_set && !nis_set && !len_err, "R1", "pulses after reset",
        {29'd0, ti_set, nis_set, len_err}, 0);
    chk(cur_ptr == 0, "R1", "pointer after reset", cur_ptr, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 base load
    tx_base = 32'h100; base_load = 1'b1;
    @(negedge clk); base_load = 1'b0;
    @(negedge clk);
    chk(cur_ptr == 32'h100, "R2", "pointer after base load", cur_ptr, 32'h100);

    // R3 unowned descriptor
    make_desc(32'h100, 32'h2000_0000, 8, 0, 32'h1000, 8'h10);
    watch_addr = 32'h100; watch_cnt = 0;
    pulse_kick(); wait_idle();
    chk(watch_cnt == 1, "R3", "single ownership read", watch_cnt, 1);
    chk(mem[32'h100 >> 2] == 32'h2000_0000, "R3", "no write-back",
        mem[32'h100 >> 2], 32'h2000_0000);
    chk(cur_ptr == 32'h100, "R3", "pointer kept", cur_ptr, 32'h100);
    chk(exp_q.size() == 0, "R3", "no bytes", exp_q.size(), 0);

    // single aligned frame, one descriptor
    t0 = ti_cnt; n0 = nis_cnt;
    make_desc(32'h100, 32'hA000_0055, 10, 0, 32'h1000, 8'h21);
    make_desc(32'h120, 32'h0000_0000, 0, 0, 32'h0, 8'h00);
    pulse_kick(); wait_idle();
    chk(exp_q.size() == 0, "R4", "aligned bytes all sent", exp_q.size(), 0);
    chk(mem[32'h100 >> 2] == 32'h2000_0055, "R6", "write-back own cleared",
        mem[32'h100 >> 2], 32'h2000_0055);
    chk(cur_ptr == 32'h120, "R7", "advance by 32", cur_ptr, 32'h120);
    chk(ti_cnt - t0 == 1 && nis_cnt - n0 == 1, "R8", "one pulse pair",
        ti_cnt - t0, 1);

    // three-descriptor frame, unaligned buffers, wrap, random ready
    ready_pct = 55; stall_viol = 0; hold_viol = 0;
    t0 = ti_cnt; e0 = err_cnt;
    make_desc(32'h120, 32'h8000_0000, 5, 0, 32'h1101, 8'h33);
    make_desc(32'h140, 32'h8000_0000, 1, 0, 32'h1203, 8'h44);
    make_desc(32'h160, 32'hA020_0000, 7, 0, 32'h1302, 8'h55);
    pulse_kick(); wait_idle();
    chk(exp_q.size() == 0, "R12", "chain fully sent", exp_q.size(), 0);
    chk(cur_ptr == 32'h100, "R7", "wrap to base", cur_ptr, 32'h100);
    chk(mem[32'h160 >> 2] == 32'h2020_0000, "R6", "wrap desc write-back",
        mem[32'h160 >> 2], 32'h2020_0000);
    chk(ti_cnt - t0 == 1, "R8", "no pulse on middle segments", ti_cnt - t0, 1);
    chk(err_cnt == e0, "R9", "no error on sane sizes", err_cnt - e0, 0);
    chk(stall_viol == 0, "R10", "request while streaming", stall_viol, 0);
    chk(hold_viol == 0, "R10", "stalled byte changed", hold_viol, 0);

    // size errors: 2048 ok, 2049 bad, buffer-2 nonzero bad
    e0 = err_cnt;
    make_desc(32'h100, 32'h8000_0000, 2048, 0, 32'h2000, 8'h01);
    make_desc(32'h120, 32'h8000_0000, 2049, 0, 32'h2800, 8'h02);
    make_desc(32'h140, 32'hA020_0000, 4, 3, 32'h3101, 8'h03);
    pulse_kick(); wait_idle();
    chk(err_cnt - e0 == 2, "R9", "error pulses", err_cnt - e0, 2);
    chk(exp_q.size() == 0, "R9", "full length still sent", exp_q.size(), 0);
    chk(cur_ptr == 32'h100, "R7", "pointer after error chain", cur_ptr, 32'h100);

    // zero-length last segment
    ready_pct = 100; t0 = ti_cnt;
    make_desc(32'h100, 32'hA000_0000, 0, 0, 32'h1000, 8'h00);
    pulse_kick(); wait_idle();
    chk(ti_cnt - t0 == 1, "R8", "pulse on empty last segment", ti_cnt - t0, 1);
    chk(mem[32'h100 >> 2] == 32'h2000_0000, "R5", "empty desc returned",
        mem[32'h100 >> 2], 32'h2000_0000);
    chk(cur_ptr == 32'h120, "R5", "pointer after empty desc", cur_ptr, 32'h120);

    // R11 kick while busy
    ready_pct = 40;
    make_desc(32'h120, 32'hA000_0000, 40, 0, 32'h1400, 8'h66);
    watch_addr = 32'h140; watch_cnt = 0;
    pulse_kick();
    repeat (12) @(negedge clk);
    pulse_kick();
    wait_idle();
    chk(exp_q.size() == 0, "R11", "bytes of busy frame", exp_q.size(), 0);
    chk(watch_cnt == 2, "R11", "re-check after busy kick", watch_cnt, 2);
    chk(cur_ptr == 32'h140, "R11", "pointer after re-check", cur_ptr, 32'h140);

    // R11 kick coincides with the unowned check
    watch_cnt = 0; coincide_addr = 32'h140;
    pulse_kick(); wait_idle();
    chk(watch_cnt == 2, "R11", "coincident kick kept", watch_cnt, 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule